// File: doc/BRIEF.md
# Serial Port Register and Interrupt Controller

This block is the register-side half of a simple byte-oriented serial port (8 data bits, no parity, one stop bit). It sits on an APB bus and holds the control settings, a one-byte transmit holding register, a one-byte receive holding register, full and overrun flags, the interrupt status, and a 20-bit baud divisor. The bit-level shifter and the baud tick generator sit outside it and are attached through small byte interfaces.

Transmit bytes leave through a valid/ready pair. Received bytes arrive as a one-cycle strobe with the byte beside it. The programmed divisor is presented to the serial engine with a flag that tells whether it is usable. Four interrupt lines (transmit done, receive data, transmit overrun, receive overrun) and their OR are driven from the status bits.

Top module: `serial_ctrl_regs`

## Requirements
- R1: After reset, state, control, interrupt status, divisor and both holding registers read as zero, every interrupt output is low, `tx_valid` is low and `baud_ok` is low.
- R2: Word offsets: 0x00 data, 0x04 state, 0x08 control, 0x0C interrupt status, 0x10 divisor. Control keeps only bits 6:0 (bit0 tx enable, bit1 rx enable, bit2 tx interrupt enable, bit3 rx interrupt enable, bit4 tx-overrun interrupt enable, bit5 rx-overrun interrupt enable, bit6 test). Offsets 0xFD0 to 0xFFC read the identification bytes 04,00,00,00,21,B8,1B,00,0D,F0,05,B1 in address order; other offsets read zero.
- R3: State bit0 is tx-full, bit1 rx-full, bit2 tx-overrun, bit3 rx-overrun. Writing state leaves bits 0 and 1 unchanged and clears bit 2 or 3 where the written value holds a 1.
- R4: A data write while tx-full is clear loads the byte and sets tx-full; `tx_valid` equals tx-full AND tx enable. A data write while tx-full is set raises tx-overrun and starts no new transfer; the holding byte takes the new value unless the pending byte is accepted in that cycle.
- R5: A cycle with `tx_valid` and `tx_ready` both high clears tx-full and, when the tx interrupt enable is set, sets interrupt status bit 0.
- R6: A byte strobed in while rx enable is clear is discarded. Otherwise it overwrites the receive holding register and sets rx-full; if rx-full was already set and data is not read in that cycle, rx-overrun is set. Interrupt status bit 1 is set when the rx interrupt enable is 1.
- R7: Reading data returns the receive holding byte and clears rx-full.
- R8: Interrupt status bit 2 equals tx-overrun AND control bit 4, bit 3 equals rx-overrun AND control bit 5. Writing 1 to any status bit clears it; for bits 2 and 3 the write also clears the matching overrun flag.
- R9: `irq_tx`, `irq_rx`, `irq_txov`, `irq_rxov` follow status bits 0 to 3, and `irq_any` is their OR.
- R10: The divisor register keeps the low 20 written bits, drives `baud_div`, and `baud_ok` is high exactly when the divisor is at least 16.
- R11: Every access completes with `pready` high and `pslverr` low; writes to identification or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always low |
| tx_byte | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_byte | input | 8 | Byte from the deserializer |
| rx_stb | input | 1 | One-cycle strobe for a new byte |
| baud_div | output | 20 | Programmed divisor |
| baud_ok | output | 1 | Divisor usable (at least 16) |
| irq_tx | output | 1 | Transmit done interrupt |
| irq_rx | output | 1 | Receive data interrupt |
| irq_txov | output | 1 | Transmit overrun interrupt |
| irq_rxov | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
The assertions assume the serializer keeps `tx_ready` as a plain level and that a control write is the only thing allowed to drop `tx_valid` before it is taken; they also assume `rx_stb` is a single-cycle pulse. The stimulus changes `tx_ready` and `rx_stb` only at falling edges, holds `tx_ready` low while a byte is being queued, and never strobes a received byte in the same cycle as a data read, so the overrun and hand-off checks see clean, ordered events.

// File: rtl/serial_ctrl_pkg.sv
package serial_ctrl_pkg;

  // word indices (byte offset >> 2)
  localparam int unsigned W_DATA  = 0;
  localparam int unsigned W_STATE = 1;
  localparam int unsigned W_CTRL  = 2;
  localparam int unsigned W_ISTAT = 3;
  localparam int unsigned W_BAUD  = 4;
  localparam int unsigned W_ID_LO = 'h3F4;
  localparam int unsigned W_ID_HI = 'h3FF;

  localparam int unsigned CTL_W = 7;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h21;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic divisor_usable(input logic [31:0] div, input int unsigned min_div);
    return div >= min_div;
  endfunction

endpackage

// File: rtl/sc_tx_hold.sv
module sc_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              load_ev,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              tx_ready,
  input  logic              ovr_clr,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_full,
  output logic              tx_ovr,
  output logic              accept_ev
);
  assign tx_valid  = tx_full & tx_en;
  assign accept_ev = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_byte <= '0;
      tx_full <= 1'b0;
      tx_ovr  <= 1'b0;
    end else begin
      if (load_ev && !tx_full) begin
        tx_byte <= load_byte;
        tx_full <= 1'b1;
      end else begin
        if (accept_ev) tx_full <= 1'b0;
        if (load_ev && !accept_ev) tx_byte <= load_byte;
      end
      if (load_ev && tx_full) tx_ovr <= 1'b1;
      else if (ovr_clr)       tx_ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_rx_hold.sv
module sc_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_stb,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              read_ev,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_hold,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              take_ev
);
  assign take_ev = rx_stb & rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (take_ev) begin
        rx_hold <= rx_byte;
        rx_full <= 1'b1;
      end else if (read_ev) begin
        rx_full <= 1'b0;
      end
      if (take_ev && rx_full && !read_ev) rx_ovr <= 1'b1;
      else if (ovr_clr)                   rx_ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_irq_unit.sv
module sc_irq_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_done_ev,
  input  logic       rx_take_ev,
  input  logic [3:0] ie,
  input  logic       tx_ovr,
  input  logic       rx_ovr,
  input  logic [1:0] w1c,
  output logic [3:0] status,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_txov,
  output logic       irq_rxov,
  output logic       irq_any
);
  logic tx_st, rx_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st <= 1'b0;
      rx_st <= 1'b0;
    end else begin
      if (tx_done_ev && ie[0]) tx_st <= 1'b1;
      else if (w1c[0])         tx_st <= 1'b0;
      if (rx_take_ev && ie[1]) rx_st <= 1'b1;
      else if (w1c[1])         rx_st <= 1'b0;
    end
  end

  assign status   = {rx_ovr & ie[3], tx_ovr & ie[2], rx_st, tx_st};
  assign irq_tx   = status[0];
  assign irq_rx   = status[1];
  assign irq_txov = status[2];
  assign irq_rxov = status[3];
  assign irq_any  = |status;
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import serial_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 20,
  parameter int unsigned MIN_DIV = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_stb,
  output logic [DIV_W-1:0]  baud_div,
  output logic              baud_ok,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_txov,
  output logic              irq_rxov,
  output logic              irq_any
);
  localparam int unsigned WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   word;
  logic              access, wr_ev, rd_ev;
  logic              wr_data_ev, rd_data_ev, ctl_wr_ev, state_wr_ev, istat_wr_ev, baud_wr_ev;
  logic              id_hit;
  logic [CTL_W-1:0]  ctl_q;
  logic [DIV_W-1:0]  baud_q;
  logic              tx_full, tx_ovr, tx_accept;
  logic              rx_full, rx_ovr, rx_take;
  logic [DATA_W-1:0] rx_hold;
  logic [3:0]        istat;
  logic              clr_txo, clr_rxo;

  assign word        = paddr[ADDR_W-1:2];
  assign access      = psel & penable;
  assign wr_ev       = access & pwrite;
  assign rd_ev       = access & ~pwrite;
  assign wr_data_ev  = wr_ev & (word == WA_W'(W_DATA));
  assign rd_data_ev  = rd_ev & (word == WA_W'(W_DATA));
  assign state_wr_ev = wr_ev & (word == WA_W'(W_STATE));
  assign ctl_wr_ev   = wr_ev & (word == WA_W'(W_CTRL));
  assign istat_wr_ev = wr_ev & (word == WA_W'(W_ISTAT));
  assign baud_wr_ev  = wr_ev & (word == WA_W'(W_BAUD));
  assign id_hit      = (word >= WA_W'(W_ID_LO)) && (word <= WA_W'(W_ID_HI));

  assign clr_txo = (state_wr_ev | istat_wr_ev) & pwdata[2];
  assign clr_rxo = (state_wr_ev | istat_wr_ev) & pwdata[3];

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctl_q  <= '0;
      baud_q <= '0;
    end else begin
      if (ctl_wr_ev)  ctl_q  <= pwdata[CTL_W-1:0];
      if (baud_wr_ev) baud_q <= pwdata[DIV_W-1:0];
    end
  end

  assign baud_div = baud_q;
  assign baud_ok  = divisor_usable(32'(baud_q), MIN_DIV);

  sc_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk(pclk), .rst_n(presetn), .tx_en(ctl_q[0]), .load_ev(wr_data_ev),
    .load_byte(pwdata[DATA_W-1:0]), .tx_ready(tx_ready), .ovr_clr(clr_txo),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_full(tx_full), .tx_ovr(tx_ovr),
    .accept_ev(tx_accept)
  );

  sc_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk(pclk), .rst_n(presetn), .rx_en(ctl_q[1]), .rx_stb(rx_stb),
    .rx_byte(rx_byte), .read_ev(rd_data_ev), .ovr_clr(clr_rxo),
    .rx_hold(rx_hold), .rx_full(rx_full), .rx_ovr(rx_ovr), .take_ev(rx_take)
  );

  sc_irq_unit u_irq (
    .clk(pclk), .rst_n(presetn), .tx_done_ev(tx_accept), .rx_take_ev(rx_take),
    .ie(ctl_q[5:2]), .tx_ovr(tx_ovr), .rx_ovr(rx_ovr),
    .w1c({istat_wr_ev & pwdata[1], istat_wr_ev & pwdata[0]}),
    .status(istat), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txov(irq_txov),
    .irq_rxov(irq_rxov), .irq_any(irq_any)
  );

  always_comb begin
    prdata = '0;
    if (id_hit) begin
      prdata[7:0] = id_byte(4'(word - WA_W'(W_ID_LO)));
    end else begin
      case (word)
        WA_W'(W_DATA):  prdata[DATA_W-1:0] = rx_hold;
        WA_W'(W_STATE): prdata[3:0]        = {rx_ovr, tx_ovr, rx_full, tx_full};
        WA_W'(W_CTRL):  prdata[CTL_W-1:0]  = ctl_q;
        WA_W'(W_ISTAT): prdata[3:0]        = istat;
        WA_W'(W_BAUD):  prdata[DIV_W-1:0]  = baud_q;
        default:        prdata             = '0;
      endcase
    end
  end
endmodule

// File: rtl/serial_ctrl_chk.sv
module serial_ctrl_chk (
  input logic pclk,
  input logic presetn,
  input logic pready,
  input logic pslverr,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_full,
  input logic tx_ovr,
  input logic tx_accept,
  input logic tx_ie,
  input logic irq_tx,
  input logic rx_full,
  input logic rx_take,
  input logic wr_data_ev,
  input logic rd_data_ev,
  input logic ctl_wr_ev
);
  assert_tx_full_clears_R5: assert property (@(posedge pclk) disable iff (!presetn)
    tx_valid && tx_ready |=> !tx_full);

  assert_tx_irq_cause_R5: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(irq_tx) |-> $past(tx_accept && tx_ie));

  assert_tx_valid_held_R4: assert property (@(posedge pclk) disable iff (!presetn)
    tx_valid && !tx_ready && !ctl_wr_ev |=> tx_valid);

  assert_tx_overrun_set_R4: assert property (@(posedge pclk) disable iff (!presetn)
    wr_data_ev && tx_full |=> tx_ovr);

  assert_rx_full_set_R6: assert property (@(posedge pclk) disable iff (!presetn)
    rx_take |=> rx_full);

  assert_rx_read_clears_R7: assert property (@(posedge pclk) disable iff (!presetn)
    rd_data_ev && !rx_take |=> !rx_full);

  assert_no_wait_no_err_R11: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);
endmodule

bind serial_ctrl_regs serial_ctrl_chk u_chk (
  .pclk(pclk), .presetn(presetn), .pready(pready), .pslverr(pslverr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_full(tx_full), .tx_ovr(tx_ovr),
  .tx_accept(tx_accept), .tx_ie(ctl_q[2]), .irq_tx(irq_tx), .rx_full(rx_full),
  .rx_take(rx_take), .wr_data_ev(wr_data_ev), .rd_data_ev(rd_data_ev),
  .ctl_wr_ev(ctl_wr_ev)
);

// File: tb/test_serial_ctrl_regs.sv
`timescale 1ns/1ps
module test_serial_ctrl_regs;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_stb = 1'b0;
  logic [19:0] baud_div;
  logic        baud_ok;
  logic        irq_tx, irq_rx, irq_txov, irq_rxov, irq_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 pclk = ~pclk;

  serial_ctrl_regs i_serial_ctrl_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_byte(rx_byte),
    .rx_stb(rx_stb), .baud_div(baud_div), .baud_ok(baud_ok), .irq_tx(irq_tx),
    .irq_rx(irq_rx), .irq_txov(irq_txov), .irq_rxov(irq_rxov), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    chk("R11 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rx_pulse(input logic [7:0] b);
    @(negedge pclk);
    rx_byte = b; rx_stb = 1'b1;
    @(negedge pclk);
    rx_stb = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge pclk);
    tx_ready = 1'b1;
    @(negedge pclk);
    tx_ready = 1'b0;
  endtask

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h21, 8'hB8,
                           8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    for (int a = 0; a < 5; a++) rd_chk("R1 reset reg", 12'(a * 4), 32'h0);
    chk("R1 reset outputs", {27'd0, tx_valid, baud_ok, irq_any, irq_tx, irq_rxov}, 32'h0);

    // R2 control keeps 7 bits
    for (int v = 0; v < 256; v += 3) begin
      wr(12'h008, 32'hFFFF_FF00 | 32'(v));
      rd_chk("R2 control readback", 12'h008, 32'(v) & 32'h7F);
    end
    wr(12'h008, 32'h0);

    // R10 divisor width and usability threshold
    for (int v = 0; v < 40; v++) begin
      wr(12'h010, 32'(v));
      rd_chk("R10 divisor readback", 12'h010, 32'(v));
      chk("R10 baud_ok", {31'd0, baud_ok}, {31'd0, v >= 16});
      chk("R10 baud_div port", {12'd0, baud_div}, 32'(v));
    end
    wr(12'h010, 32'h0010_0008);
    rd_chk("R10 divisor masked", 12'h010, 32'h8);
    chk("R10 masked low", {31'd0, baud_ok}, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R10 divisor max", 12'h010, 32'hF_FFFF);
    chk("R10 max ok", {31'd0, baud_ok}, 32'h1);

    // R2 identification bytes, R11 ignored writes
    for (int i = 0; i < 12; i++) rd_chk("R2 id byte", 12'(12'hFD0 + i * 4), 32'(exp_id(i)));
    wr(12'hFE0, 32'hFF);
    rd_chk("R11 id write ignored", 12'hFE0, 32'h21);
    wr(12'h014, 32'h7F);
    rd_chk("R2 unmapped reads zero", 12'h014, 32'h0);
    rd_chk("R11 ctrl untouched", 12'h008, 32'h0);
    rd_chk("R2 unmapped 0x100", 12'h100, 32'h0);
    rd_chk("R2 unmapped 0xFCC", 12'hFCC, 32'h0);

    // R4 / R5 transmit path
    wr(12'h008, 32'h05);
    wr(12'h000, 32'h3C);
    chk("R4 valid after load", {23'd0, tx_valid, tx_byte}, 32'h13C);
    rd_chk("R4 state tx-full", 12'h004, 32'h1);
    wr(12'h000, 32'hC3);
    rd_chk("R4 state overrun", 12'h004, 32'h5);
    chk("R4 holding replaced", {23'd0, tx_valid, tx_byte}, 32'h1C3);
    tx_take();
    chk("R5 valid dropped", {31'd0, tx_valid}, 32'h0);
    rd_chk("R5 state after accept", 12'h004, 32'h4);
    rd_chk("R5 tx status bit", 12'h00C, 32'h1);
    chk("R9 tx lines", {30'd0, irq_tx, irq_any}, 32'h3);
    wr(12'h008, 32'h04);
    wr(12'h000, 32'h11);
    chk("R4 no valid when disabled", {31'd0, tx_valid}, 32'h0);
    rd_chk("R4 full while disabled", 12'h004, 32'h5);
    wr(12'h008, 32'h05);
    chk("R4 valid on enable", {23'd0, tx_valid, tx_byte}, 32'h111);
    tx_take();
    rd_chk("R5 second accept", 12'h004, 32'h4);

    // R6 / R7 receive path
    wr(12'h008, 32'h00);
    rx_pulse(8'h77);
    rd_chk("R6 disabled discard", 12'h004, 32'h4);
    rd_chk("R6 no rx status", 12'h00C, 32'h1);
    wr(12'h008, 32'h0A);
    rx_pulse(8'h5A);
    rd_chk("R6 rx-full set", 12'h004, 32'h6);
    rd_chk("R6 rx status bit", 12'h00C, 32'h3);
    chk("R9 rx line", {31'd0, irq_rx}, 32'h1);
    wr(12'h004, 32'h3);
    rd_chk("R3 read-only bits kept", 12'h004, 32'h6);
    rd_chk("R7 data byte", 12'h000, 32'h5A);
    rd_chk("R7 rx-full cleared", 12'h004, 32'h4);
    rx_pulse(8'h11);
    rx_pulse(8'h22);
    rd_chk("R6 overrun set", 12'h004, 32'hE);
    rd_chk("R6 overwrite", 12'h000, 32'h22);
    rd_chk("R7 clear keeps overrun", 12'h004, 32'hC);

    // R8 / R9 overrun status masking sweep
    for (int e = 0; e < 4; e++) begin
      wr(12'h008, 32'(e << 4));
      rd_chk("R8 overrun status mask", 12'h00C, 32'((e << 2) | 3));
      chk("R9 overrun lines", {30'd0, irq_rxov, irq_txov}, 32'(e));
    end

    // R3 / R8 / R9 clearing
    wr(12'h004, 32'h4);
    rd_chk("R3 w1c tx-overrun", 12'h004, 32'h8);
    rd_chk("R8 status follows flag", 12'h00C, 32'hB);
    wr(12'h00C, 32'h8);
    rd_chk("R8 status clears flag", 12'h004, 32'h0);
    rd_chk("R8 status after clear", 12'h00C, 32'h3);
    wr(12'h00C, 32'h1);
    rd_chk("R8 w1c tx bit", 12'h00C, 32'h2);
    chk("R9 lines after tx clear", {29'd0, irq_tx, irq_rx, irq_any}, 32'h3);
    wr(12'h00C, 32'h2);
    rd_chk("R8 w1c rx bit", 12'h00C, 32'h0);
    chk("R9 combined low", {31'd0, irq_any}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule